// File: doc/BRIEF.md
# Multi-Port Register File with Registered Read and Delayed Bypass

This block is the operand store for a dual-issue pipeline. It holds 32 entries of 32 bits and serves four reads and two writes in every clock cycle. Writes commit on the rising edge. Reads are registered: an address presented in one cycle produces its data on the output after the next rising edge. A pipeline that uses the block must issue its register reads one stage earlier than it would with a combinational read.

A write can commit at the same edge that samples a read address. The stored value sampled at that edge is then stale. To cover this, the block captures the committing writes alongside the sampled read addresses. In the following cycle it compares them and selects the newest value on the output side of the read register. Write port 1 has priority over write port 0, both for storage and for forwarding. Register 0 always reads as zero, and writes to it are dropped.

The entry count, the data width and the number of read ports are parameters. They are checked at elaboration.

Top module: `mpreg_file`

## Requirements
- R1: While the synchronous reset `rst` is high and in the cycle after it, every read output is zero. No forwarding occurs from writes seen during reset.
- R2: Read data is registered. The output of read lane k after a rising edge is the content of the register addressed by lane k's address in the cycle before that edge, including any write that commits at that same edge.
- R3: A write commits at the rising edge only when its enable is high. With the enable low, neither the address nor the data changes any register.
- R4: When both write enables are high with equal nonzero addresses, only port 1's data is stored in that register.
- R5: A write committing at the edge that samples a read address is forwarded, so the read returns the new value rather than the stored old one.
- R6: When both write ports hit the sampled read address, port 1's data is forwarded. Port 0's data is forwarded only when port 1 does not hit that address.
- R7: Writes to address 0 from either port are discarded, and any read of address 0 returns zero.
- R8: A write in cycle N followed by a read of the same register presented in cycle N+1 returns the written value.
- R9: Two writes to different registers in one cycle both commit. Reads of both registers in that same cycle each return their own new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr | input | NRD*AW (20) | Read addresses, lane k in bits [k*AW +: AW] |
| rd_data | output | NRD*DW (128) | Registered read data, lane k in bits [k*DW +: DW] |
| wen0 | input | 1 | Write port 0 enable |
| waddr0 | input | AW (5) | Write port 0 address |
| wdata0 | input | DW (32) | Write port 0 data |
| wen1 | input | 1 | Write port 1 enable (higher priority) |
| waddr1 | input | AW (5) | Write port 1 address |
| wdata1 | input | DW (32) | Write port 1 data |

## Verification
On every cycle, the bound checker verifies the forwarding path on each lane. A read whose address met a committing port 1 write must return that data. Otherwise a port 0 match must return port 0's data. Reads of address 0 must return zero. The checker also confirms that the write resolver never lets port 0 commit against a port 1 write to the same address, and never lets either port commit to address 0.

Some behaviours can be shown only by the bench's scenarios, because they need the stored contents over several cycles. These are values surviving disabled writes with random data, the port 1 value persisting after a dual write, the write-then-read-next-cycle order, and the reset state. The bench compares all four lanes every cycle against a reference array model. It uses directed cases first, then random traffic biased toward colliding addresses.

// File: rtl/mpreg_pkg.sv
package mpreg_pkg;

   // Source picked by a read lane's output mux
   typedef enum logic [1:0] {
      SRC_ARRAY = 2'd0,
      SRC_WP0   = 2'd1,
      SRC_WP1   = 2'd2,
      SRC_ZERO  = 2'd3
   } rd_src_e;

   function automatic rd_src_e pick_src(
      input logic [15:0] addr,
      input logic        we0,
      input logic [15:0] wa0,
      input logic        we1,
      input logic [15:0] wa1
   );
      if (addr == '0)                  return SRC_ZERO;
      else if (we1 && (wa1 == addr))   return SRC_WP1;
      else if (we0 && (wa0 == addr))   return SRC_WP0;
      else                             return SRC_ARRAY;
   endfunction

endpackage

// File: rtl/mpreg_wr_resolve.sv
module mpreg_wr_resolve #(
   parameter int AW = 5
) (
   input  logic          wen0,
   input  logic [AW-1:0] waddr0,
   input  logic          wen1,
   input  logic [AW-1:0] waddr1,
   output logic          commit0,
   output logic          commit1
);
   logic clash;

   always_comb begin
      clash   = wen1 && (waddr1 == waddr0);
      commit1 = wen1 && (waddr1 != '0);
      commit0 = wen0 && (waddr0 != '0) && !clash;
   end
endmodule

// File: rtl/mpreg_storage.sv
module mpreg_storage #(
   parameter int NREG = 32,
   parameter int DW   = 32,
   parameter int AW   = 5,
   parameter int NRD  = 4
) (
   input  logic              clk,
   input  logic              we0,
   input  logic [AW-1:0]     wa0,
   input  logic [DW-1:0]     wd0,
   input  logic              we1,
   input  logic [AW-1:0]     wa1,
   input  logic [DW-1:0]     wd1,
   input  logic [NRD*AW-1:0] raddr,
   output logic [NRD*DW-1:0] rraw
);
   logic [DW-1:0] mem [NREG];

   // Port 1 is applied last; the resolver already keeps the two apart.
   always_ff @(posedge clk) begin
      if (we0) mem[32'(wa0)] <= wd0;
      if (we1) mem[32'(wa1)] <= wd1;
   end

   for (genvar k = 0; k < NRD; k++) begin : g_rd
      logic [AW-1:0] a;
      assign a = raddr[k*AW +: AW];
      assign rraw[k*DW +: DW] = (32'(a) < NREG) ? mem[32'(a)] : '0;
   end
endmodule

// File: rtl/mpreg_rd_lane.sv
module mpreg_rd_lane
   import mpreg_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] raw,
   input  logic          cap_we0,
   input  logic [AW-1:0] cap_wa0,
   input  logic [DW-1:0] cap_wd0,
   input  logic          cap_we1,
   input  logic [AW-1:0] cap_wa1,
   input  logic [DW-1:0] cap_wd1,
   output logic [DW-1:0] dout
);
   logic [AW-1:0] addr_q;
   logic [DW-1:0] raw_q;
   rd_src_e       src;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         raw_q  <= '0;
      end else begin
         addr_q <= addr;
         raw_q  <= raw;
      end
   end

   always_comb begin
      src = pick_src(16'(addr_q), cap_we0, 16'(cap_wa0), cap_we1, 16'(cap_wa1));
      unique case (src)
         SRC_ZERO: dout = '0;
         SRC_WP1:  dout = cap_wd1;
         SRC_WP0:  dout = cap_wd0;
         default:  dout = raw_q;
      endcase
   end
endmodule

// File: rtl/mpreg_file.sv
module mpreg_file #(
   parameter int NREG = 32,
   parameter int DW   = 32,
   parameter int NRD  = 4,
   parameter int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NRD*AW-1:0] rd_addr,
   output logic [NRD*DW-1:0] rd_data,
   input  logic              wen0,
   input  logic [AW-1:0]     waddr0,
   input  logic [DW-1:0]     wdata0,
   input  logic              wen1,
   input  logic [AW-1:0]     waddr1,
   input  logic [DW-1:0]     wdata1
);
   localparam int RAWW = NRD * DW;

   if (NREG < 2 || NREG > 65536) begin : g_bad_nreg
      $error("mpreg_file: NREG out of range");
   end
   if ((1 << AW) < NREG) begin : g_bad_aw
      $error("mpreg_file: AW too narrow for NREG");
   end
   if (NRD < 1 || DW < 1) begin : g_bad_shape
      $error("mpreg_file: NRD and DW must be positive");
   end

   logic            c_we0, c_we1;
   logic [RAWW-1:0] raw_rd;

   // Captured writes of the cycle whose read addresses the lanes hold
   logic            cap_we0, cap_we1;
   logic [AW-1:0]   cap_wa0, cap_wa1;
   logic [DW-1:0]   cap_wd0, cap_wd1;

   mpreg_wr_resolve #(.AW(AW)) i_resolve (
      .wen0   (wen0),
      .waddr0 (waddr0),
      .wen1   (wen1),
      .waddr1 (waddr1),
      .commit0(c_we0),
      .commit1(c_we1)
   );

   mpreg_storage #(.NREG(NREG), .DW(DW), .AW(AW), .NRD(NRD)) i_store (
      .clk  (clk),
      .we0  (c_we0),
      .wa0  (waddr0),
      .wd0  (wdata0),
      .we1  (c_we1),
      .wa1  (waddr1),
      .wd1  (wdata1),
      .raddr(rd_addr),
      .rraw (raw_rd)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_we0 <= 1'b0;
         cap_we1 <= 1'b0;
      end else begin
         cap_we0 <= c_we0;
         cap_we1 <= c_we1;
      end
      cap_wa0 <= waddr0;
      cap_wd0 <= wdata0;
      cap_wa1 <= waddr1;
      cap_wd1 <= wdata1;
   end

   for (genvar k = 0; k < NRD; k++) begin : g_lane
      mpreg_rd_lane #(.DW(DW), .AW(AW)) i_lane (
         .clk    (clk),
         .rst    (rst),
         .addr   (rd_addr[k*AW +: AW]),
         .raw    (raw_rd[k*DW +: DW]),
         .cap_we0(cap_we0),
         .cap_wa0(cap_wa0),
         .cap_wd0(cap_wd0),
         .cap_we1(cap_we1),
         .cap_wa1(cap_wa1),
         .cap_wd1(cap_wd1),
         .dout   (rd_data[k*DW +: DW])
      );
   end
endmodule

// File: rtl/mpreg_file_chk.sv
module mpreg_file_chk #(
   parameter int DW  = 32,
   parameter int AW  = 5,
   parameter int NRD = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [NRD*AW-1:0] rd_addr,
   input logic [NRD*DW-1:0] rd_data,
   input logic              wen0,
   input logic [AW-1:0]     waddr0,
   input logic [DW-1:0]     wdata0,
   input logic              wen1,
   input logic [AW-1:0]     waddr1,
   input logic [DW-1:0]     wdata1,
   input logic              c_we0,
   input logic              c_we1
);
   // R4
   wr_clash_chk: assert property (@(posedge clk) disable iff (rst)
      (wen0 && wen1 && (waddr0 == waddr1)) |-> !c_we0);

   // R7
   zero_wr_chk: assert property (@(posedge clk) disable iff (rst)
      ((waddr0 == '0) |-> !c_we0) and ((waddr1 == '0) |-> !c_we1));

   for (genvar k = 0; k < NRD; k++) begin : g_lane_chk
      // R7
      zero_rd_chk: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && ($past(rd_addr[k*AW +: AW]) == '0))
         |-> (rd_data[k*DW +: DW] == '0));

      // R6
      fwd_p1_chk: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(wen1) && ($past(waddr1) != '0) &&
          ($past(waddr1) == $past(rd_addr[k*AW +: AW])))
         |-> (rd_data[k*DW +: DW] == $past(wdata1)));

      // R5
      fwd_p0_chk: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(wen0) && ($past(waddr0) != '0) &&
          ($past(waddr0) == $past(rd_addr[k*AW +: AW])) &&
          !($past(wen1) && ($past(waddr1) == $past(waddr0))))
         |-> (rd_data[k*DW +: DW] == $past(wdata0)));
   end
endmodule

bind mpreg_file mpreg_file_chk #(.DW(DW), .AW(AW), .NRD(NRD)) i_chk (
   .clk    (clk),
   .rst    (rst),
   .rd_addr(rd_addr),
   .rd_data(rd_data),
   .wen0   (wen0),
   .waddr0 (waddr0),
   .wdata0 (wdata0),
   .wen1   (wen1),
   .waddr1 (waddr1),
   .wdata1 (wdata1),
   .c_we0  (c_we0),
   .c_we1  (c_we1)
);

// File: tb/test_mpreg_file.sv
`timescale 1ns/1ps
module test_mpreg_file;
   localparam int NREG = 32;
   localparam int DW   = 32;
   localparam int NRD  = 4;
   localparam int AW   = 5;

   logic              clk = 1'b0;
   logic              rst;
   logic [NRD*AW-1:0] rd_addr;
   logic [NRD*DW-1:0] rd_data;
   logic              wen0, wen1;
   logic [AW-1:0]     waddr0, waddr1;
   logic [DW-1:0]     wdata0, wdata1;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [DW-1:0] model [NREG];

   always #10 clk = ~clk;

   mpreg_file #(.NREG(NREG), .DW(DW), .NRD(NRD)) i_mpreg_file (
      .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
      .wen0(wen0), .waddr0(waddr0), .wdata0(wdata0),
      .wen1(wen1), .waddr1(waddr1), .wdata1(wdata1)
   );

   // Reference value of a register after the edge's writes (R4, R7 rules)
   function automatic logic [DW-1:0] ref_after(input int a, input bit w0, input int a0,
      input logic [DW-1:0] d0, input bit w1, input int a1, input logic [DW-1:0] d1);
      if (a == 0) return '0;
      if (w1 && a1 == a) return d1;
      if (w0 && a0 == a) return d0;
      return model[a];
   endfunction

   task automatic check(input string tag, input int lane, input logic [DW-1:0] exp);
      logic [DW-1:0] got;
      got = rd_data[lane*DW +: DW];
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s lane %0d: got %h expected %h", tag, lane, got, exp);
      end
   endtask

   // One cycle: drive, clock, update model, compare all lanes at negedge
   task automatic cyc(input string tag, input int a0, input int a1, input int a2, input int a3,
      input bit w0, input int wa0, input logic [DW-1:0] wd0,
      input bit w1, input int wa1, input logic [DW-1:0] wd1);
      logic [DW-1:0] exp [NRD];
      int ra [NRD];
      ra[0] = a0; ra[1] = a1; ra[2] = a2; ra[3] = a3;
      for (int k = 0; k < NRD; k++) rd_addr[k*AW +: AW] = AW'(ra[k]);
      wen0 = w0; waddr0 = AW'(wa0); wdata0 = wd0;
      wen1 = w1; waddr1 = AW'(wa1); wdata1 = wd1;
      for (int k = 0; k < NRD; k++) exp[k] = ref_after(ra[k], w0, wa0, wd0, w1, wa1, wd1);
      @(posedge clk);
      for (int a = 1; a < NREG; a++) model[a] = ref_after(a, w0, wa0, wd0, w1, wa1, wd1);
      @(negedge clk);
      for (int k = 0; k < NRD; k++) check(tag, k, exp[k]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd5150));
      for (int a = 0; a < NREG; a++) model[a] = '0;
      rst = 1'b1;
      rd_addr = {NRD{AW'(5'd9)}};
      wen0 = 1'b1; waddr0 = 5'd9; wdata0 = 32'h1111_2222;
      wen1 = 1'b1; waddr1 = 5'd9; wdata1 = 32'h3333_4444;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs zero during reset
      for (int k = 0; k < NRD; k++) check("R1", k, '0);
      wen0 = 1'b0; wen1 = 1'b0; rd_addr = '0;
      @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      for (int k = 0; k < NRD; k++) check("R1", k, '0);

      // Fill every register: R9 pairs of writes in one cycle
      for (int a = 1; a < NREG; a += 2) begin
         int b;
         b = (a + 1 < NREG) ? a + 1 : a;
         cyc("R9", a, b, 0, a, 1'b1, a, 32'hA000_0000 | 32'(a),
             (b != a), b, 32'hB000_0000 | 32'(b));
      end

      // R4 / R6: dual write to same register, all lanes read it
      cyc("R6", 7, 7, 7, 7, 1'b1, 7, 32'hAAAA_AAAA, 1'b1, 7, 32'hBBBB_BBBB);
      cyc("R4", 7, 7, 6, 8, 1'b0, 0, '0, 1'b0, 0, '0);

      // R9 / R5: two different registers written, read in same cycle
      cyc("R5", 3, 9, 5, 0, 1'b1, 3, 32'h0303_0303, 1'b1, 9, 32'h0909_0909);
      cyc("R9", 3, 9, 3, 9, 1'b0, 0, '0, 1'b0, 0, '0);

      // R3: disabled writes with random data leave storage alone
      cyc("R3", 12, 13, 12, 13, 1'b0, 12, $urandom, 1'b0, 13, $urandom);
      cyc("R3", 12, 13, 12, 13, 1'b0, 0, '0, 1'b0, 0, '0);

      // R7: writes to register 0 from both ports, then reads of it
      cyc("R7", 0, 0, 0, 0, 1'b1, 0, 32'hDEAD_0000, 1'b0, 0, '0);
      cyc("R7", 0, 0, 0, 0, 1'b0, 0, '0, 1'b1, 0, 32'hDEAD_1111);
      cyc("R7", 0, 0, 0, 0, 1'b1, 0, 32'h5A5A_5A5A, 1'b1, 0, 32'hA5A5_A5A5);

      // R8: write in N, read presented in N+1
      cyc("R8", 1, 2, 4, 6, 1'b1, 20, 32'h2020_2020, 1'b0, 0, '0);
      cyc("R8", 20, 20, 1, 20, 1'b0, 0, '0, 1'b0, 0, '0);

      // R6: port 0 forwarded when port 1 targets elsewhere
      cyc("R6", 15, 16, 15, 16, 1'b1, 15, 32'hF0F0_0015, 1'b1, 16, 32'h0F0F_0016);

      // R2: random traffic biased toward collisions
      for (int i = 0; i < 3000; i++) begin
         int r [NRD];
         int x0, x1;
         bit hot;
         hot = ($urandom % 3) != 0;
         for (int k = 0; k < NRD; k++) r[k] = hot ? int'($urandom % 4) : int'($urandom % NREG);
         x0 = hot ? int'($urandom % 4) : int'($urandom % NREG);
         x1 = hot ? int'($urandom % 4) : int'($urandom % NREG);
         cyc("R2", r[0], r[1], r[2], r[3], 1'($urandom), x0, $urandom,
             1'($urandom), x1, $urandom);
      end

      finish_run();
   end
endmodule